// File: doc/BRIEF.md
# Correlated-Sample Successive-Approximation Controller

This block is the digital sequencer of a successive-approximation converter. It does not open every conversion with a fixed top-down binary search. It reuses the code of the previous sample as the starting point. From there it walks outward with small steps that double each cycle until the comparator reverses. It then bisects the bracket it has found. When consecutive samples lie close together, a conversion needs only a few comparator decisions. The comparator decision count is reported per sample, because comparator energy scales with it.

The block has a second mode for less predictable signals. In this mode it first tests the two edges of a fixed window centred on the previous code. This takes two cycles. It then bisects whichever part of the range holds the input. Each cycle the controller drives one trial code to the DAC and reads back one comparator bit. That bit is 1 when the analog input lies above the DAC level. The capacitor array and the comparator are outside this block.

Top module: `sar_lsb_ctrl`

## Requirements
- R1: The final code is the smallest code c for which the comparator bit (1 = input above DAC code c) is 0. For an integer input v in 0..2^RES_W-1 this equals v, in both modes.
- R2: In tracking mode (subrange_i = 0) the first trial code equals the previous result on code_o. After reset code_o is 2^(RES_W-1) (512 for the default RES_W = 10).
- R3: In tracking mode, after the first decision the trials move away from the previous code by +/-1, +/-2, +/-4, and so on. The sign is + when that first decision was 1. Growth stops when the decision differs from the first one. The block then bisects the known bracket at the lower midpoint lo+(hi-lo)/2.
- R4: Every trial code lies in 0..2^RES_W-1. A growth trial that would pass a rail is clamped to that rail. After a trial at the rail, growth ends.
- R5: ncmp_o gives the number of comparator decisions used by the last conversion. It equals the number of clock edges from the start edge to the edge that raises done_o, and it never exceeds 2*RES_W+2.
- R6: done_o is high for exactly one cycle per conversion. code_o and ncmp_o stay constant from then until the next accepted start.
- R7: A start_i pulse while busy_o is high is ignored. The running conversion keeps its mode, its trials and its count.
- R8: In window mode (subrange_i = 1) the first trial is the previous code + 2^WIN_LOG and the second is the previous code - 2^WIN_LOG, each clamped to the rails. The second trial is skipped when the first decision is 1. Bisection of the remaining bracket follows.
- R9: In tracking mode, an input within 2 codes of the previous result converts in fewer than RES_W decisions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a conversion (accepted only when idle) |
| subrange_i | input | 1 | Mode for this conversion: 0 tracking, 1 window |
| cmp_above_i | input | 1 | Comparator decision for the current dac_code_o: 1 = input above |
| dac_code_o | output | RES_W | Trial code driven to the DAC |
| code_o | output | RES_W | Result of the last conversion; seed for the next |
| done_o | output | 1 | One-cycle strobe at the end of a conversion |
| busy_o | output | 1 | Conversion in progress |
| ncmp_o | output | CNT_W | Comparator decisions used by the last conversion |

## Verification
The bench replays exact trial sequences to catch three faults: growth that jumps by the wrong power of two, growth that goes the wrong way, and bisection that uses the upper midpoint. Each of these shows up as a wrong trace or a wrong count even when the final code happens to be right. It drives conversions that run into both rails. A controller that wrapped instead of clamping would then present out-of-range or wrapped trials and settle on a wrong code. A second start is injected in mid-conversion; a design that restarted on it would report a different decision count. The bench also holds the result idle and confirms that it stays put and that the done strobe lasts one cycle. On a slow ramp it confirms that decision counts stay below RES_W.

// File: rtl/sar_lsb_pkg.sv
package sar_lsb_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SEED,
    PH_GROW,
    PH_WIN_HI,
    PH_WIN_LO,
    PH_REFINE
  } phase_e;
endpackage

// File: rtl/sar_bracket.sv
// Narrows the [lo, hi] bracket with one comparator decision on trial_i.
module sar_bracket #(
  parameter int RES_W = 10
) (
  input  logic [RES_W-1:0] trial_i,
  input  logic [RES_W-1:0] lo_i,
  input  logic [RES_W-1:0] hi_i,
  input  logic             above_i,
  output logic [RES_W-1:0] lo_o,
  output logic [RES_W-1:0] hi_o,
  output logic             pinned_o
);
  localparam logic [RES_W-1:0] MAXC = '1;

  always_comb begin
    lo_o = lo_i;
    hi_o = hi_i;
    if (above_i) lo_o = (trial_i == MAXC) ? MAXC : trial_i + 1'b1;
    else         hi_o = trial_i;
    pinned_o = (lo_o >= hi_o);
  end
endmodule

// File: rtl/sar_trial_gen.sv
// Candidate next trials: clamped growth step, lower midpoint, window edges.
module sar_trial_gen #(
  parameter int RES_W   = 10,
  parameter int WIN_LOG = 3,
  parameter bit WIN_EN  = 1'b1
) (
  input  logic [RES_W-1:0] anchor_i,
  input  logic [RES_W:0]   step_i,
  input  logic             up_i,
  input  logic [RES_W-1:0] lo_i,
  input  logic [RES_W-1:0] hi_i,
  output logic [RES_W-1:0] grow_o,
  output logic [RES_W-1:0] mid_o,
  output logic [RES_W-1:0] win_hi_o,
  output logic [RES_W-1:0] win_lo_o
);
  localparam int XW = RES_W + 2;
  localparam logic [XW-1:0] MAX_X = XW'((1 << RES_W) - 1);

  logic [XW-1:0]    anc_x, stp_x, up_sum;
  logic [RES_W-1:0] span;

  assign anc_x  = XW'(anchor_i);
  assign stp_x  = XW'(step_i);
  assign up_sum = anc_x + stp_x;

  always_comb begin
    if (up_i) grow_o = (up_sum > MAX_X) ? MAX_X[RES_W-1:0] : up_sum[RES_W-1:0];
    else      grow_o = (stp_x >= anc_x) ? '0 : RES_W'(anc_x - stp_x);
  end

  assign span  = hi_i - lo_i;
  assign mid_o = lo_i + (span >> 1);

  generate
    if (WIN_EN) begin : g_win
      localparam logic [XW-1:0] WIN_X = XW'(1 << WIN_LOG);
      logic [XW-1:0] hi_sum;
      assign hi_sum   = anc_x + WIN_X;
      assign win_hi_o = (hi_sum > MAX_X) ? MAX_X[RES_W-1:0] : hi_sum[RES_W-1:0];
      assign win_lo_o = (anc_x > WIN_X) ? RES_W'(anc_x - WIN_X) : '0;
    end else begin : g_nowin
      assign win_hi_o = anchor_i;
      assign win_lo_o = anchor_i;
    end
  endgenerate
endmodule

// File: rtl/sar_cmp_counter.sv
// Comparator decision counter; cleared on start, held when idle.
module sar_cmp_counter #(
  parameter int CNT_W   = 5,
  parameter int CNT_MAX = 22
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   cnt_q <= '0;
    else if (clr_i)                                cnt_q <= '0;
    else if (inc_i && (cnt_q != CNT_W'(CNT_MAX)))  cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  // search must finish before the count limit is reached
  p_cnt_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i |-> (cnt_q < CNT_W'(CNT_MAX)));
endmodule

// File: rtl/sar_lsb_ctrl.sv
module sar_lsb_ctrl
  import sar_lsb_pkg::*;
#(
  parameter int  RES_W       = 10,
  parameter int  WIN_LOG     = 3,
  parameter bit  SUBRANGE_EN = 1'b1,
  localparam int MAX_CMP     = 2 * RES_W + 2,
  localparam int CNT_W       = $clog2(MAX_CMP + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             subrange_i,
  input  logic             cmp_above_i,
  output logic [RES_W-1:0] dac_code_o,
  output logic [RES_W-1:0] code_o,
  output logic             done_o,
  output logic             busy_o,
  output logic [CNT_W-1:0] ncmp_o
);
  localparam logic [RES_W-1:0] MAXC = '1;
  localparam logic [RES_W-1:0] MIDC = RES_W'(1 << (RES_W - 1));

  phase_e           phase_q;
  logic [RES_W-1:0] trial_q, lo_q, hi_q, code_q;
  logic [RES_W:0]   step_q;
  logic             up_q, done_q;

  logic             busy, start_go, sub_sel, at_rail, dir_nx, pinned;
  logic [RES_W:0]   step_nx;
  logic [RES_W-1:0] lo_n, hi_n, grow_t, mid_t, win_hi_t, win_lo_t;

  assign busy     = (phase_q != PH_IDLE);
  assign start_go = start_i && !busy;
  assign sub_sel  = SUBRANGE_EN && subrange_i;
  assign at_rail  = up_q ? (trial_q == MAXC) : (trial_q == '0);

  // first growth step takes its direction from the seed decision
  always_comb begin
    if (phase_q == PH_SEED) begin
      dir_nx  = cmp_above_i;
      step_nx = (RES_W+1)'(1);
    end else begin
      dir_nx  = up_q;
      step_nx = step_q << 1;
    end
  end

  sar_bracket #(.RES_W(RES_W)) u_bracket (
    .trial_i  (trial_q),
    .lo_i     (lo_q),
    .hi_i     (hi_q),
    .above_i  (cmp_above_i),
    .lo_o     (lo_n),
    .hi_o     (hi_n),
    .pinned_o (pinned)
  );

  sar_trial_gen #(.RES_W(RES_W), .WIN_LOG(WIN_LOG), .WIN_EN(SUBRANGE_EN)) u_trial (
    .anchor_i (code_q),
    .step_i   (step_nx),
    .up_i     (dir_nx),
    .lo_i     (lo_n),
    .hi_i     (hi_n),
    .grow_o   (grow_t),
    .mid_o    (mid_t),
    .win_hi_o (win_hi_t),
    .win_lo_o (win_lo_t)
  );

  sar_cmp_counter #(.CNT_W(CNT_W), .CNT_MAX(MAX_CMP)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (start_go),
    .inc_i  (busy),
    .cnt_o  (ncmp_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      trial_q <= MIDC;
      lo_q    <= '0;
      hi_q    <= MAXC;
      step_q  <= '0;
      up_q    <= 1'b0;
      code_q  <= MIDC;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_go) begin
        phase_q <= sub_sel ? PH_WIN_HI : PH_SEED;
        trial_q <= sub_sel ? win_hi_t : code_q;
        lo_q    <= '0;
        hi_q    <= MAXC;
        step_q  <= '0;
        up_q    <= 1'b0;
      end else if (busy) begin
        lo_q <= lo_n;
        hi_q <= hi_n;
        if (pinned) begin
          phase_q <= PH_IDLE;
          code_q  <= lo_n;
          done_q  <= 1'b1;
        end else begin
          unique case (phase_q)
            PH_SEED: begin
              up_q    <= dir_nx;
              step_q  <= step_nx;
              trial_q <= grow_t;
              phase_q <= PH_GROW;
            end
            PH_GROW: begin
              if ((cmp_above_i == up_q) && !at_rail) begin
                step_q  <= step_nx;
                trial_q <= grow_t;
              end else begin
                trial_q <= mid_t;
                phase_q <= PH_REFINE;
              end
            end
            PH_WIN_HI: begin
              if (cmp_above_i) begin
                trial_q <= mid_t;
                phase_q <= PH_REFINE;
              end else begin
                trial_q <= win_lo_t;
                phase_q <= PH_WIN_LO;
              end
            end
            PH_WIN_LO: begin
              trial_q <= mid_t;
              phase_q <= PH_REFINE;
            end
            PH_REFINE: trial_q <= mid_t;
            default:   phase_q <= PH_IDLE;
          endcase
        end
      end
    end
  end

  assign dac_code_o = trial_q;
  assign code_o     = code_q;
  assign done_o     = done_q;
  assign busy_o     = busy;

  p_trial_bracket_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> ((lo_q <= trial_q) && (trial_q <= hi_q)));

  p_seed_prev_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && !subrange_i) |=> (dac_code_o == code_o));

  p_step_pow2_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_GROW) |-> ($countones(step_q) == 1));

  p_done_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_code_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(code_o) |-> done_o);

  p_done_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  p_start_ignored_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> (busy_o || done_o));

  p_win_first_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && subrange_i) |=> (dac_code_o >= code_o));
endmodule

// File: tb/sar_lsb_ctrl_tb.sv
`timescale 1ns/1ps
module sar_lsb_ctrl_tb_top;
  localparam int RES_W  = 10;
  localparam int CNT_W  = $clog2(2 * RES_W + 3);
  localparam int N_VEC  = 12;
  localparam int VEC_VIN [N_VEC] = '{301, 303, 302, 302, 300, 299, 640, 641, 20, 21, 1023, 1022};
  localparam bit VEC_SUB [N_VEC] = '{0, 0, 0, 1, 0, 0, 1, 0, 0, 1, 0, 0};

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic             sub = 1'b0;
  logic             cmp_above;
  logic [RES_W-1:0] dac_code, code;
  logic             done, busy;
  logic [CNT_W-1:0] ncmp;
  int               vin = 0;

  int n_chk = 0;
  int n_fail = 0;
  int tr [64];
  int ntr, lat, got_code, got_cnt;

  always #2.5 clk = ~clk;

  assign cmp_above = (vin > int'(dac_code));

  sar_lsb_ctrl #(.RES_W(RES_W)) dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .start_i     (start),
    .subrange_i  (sub),
    .cmp_above_i (cmp_above),
    .dac_code_o  (dac_code),
    .code_o      (code),
    .done_o      (done),
    .busy_o      (busy),
    .ncmp_o      (ncmp)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // runs one conversion; intr >= 0 injects a window-mode start at that cycle
  task automatic convert(input bit mode, input int v, input int intr);
    @(negedge clk);
    vin   = v;
    sub   = mode;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    ntr   = 0;
    lat   = 0;
    forever begin
      if (busy && ntr < 64) begin
        tr[ntr] = int'(dac_code);
        ntr++;
      end
      @(negedge clk);
      lat++;
      start = (lat == intr);
      if (lat == intr) sub = 1'b1;
      if (done) break;
      if (lat > 200) begin
        chk(1'b0, "watchdog", lat, 0);
        break;
      end
    end
    start    = 1'b0;
    got_code = int'(code);
    got_cnt  = int'(ncmp);
    chk(got_code == v, "R1 code", got_code, v);
    chk(got_cnt == lat, "R5 count vs latency", got_cnt, lat);
    chk(got_cnt <= 2 * RES_W + 2, "R5 count bound", got_cnt, 2 * RES_W + 2);
    @(negedge clk);
    chk(done == 1'b0, "R6 done width", int'(done), 0);
  endtask

  initial begin
    #500us;
    chk(1'b0, "watchdog global", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int prev;
    repeat (3) @(negedge clk);
    // reset state, R2
    chk(int'(code) == 512, "R2 reset code", int'(code), 512);
    chk(done == 1'b0 && busy == 1'b0, "R6 reset strobes", int'({done, busy}), 0);
    chk(int'(ncmp) == 0, "R5 reset count", int'(ncmp), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: equal input, seed then one step down
    convert(1'b0, 512, -1);
    chk(tr[0] == 512, "R2 first trial", tr[0], 512);
    chk(got_cnt == 2, "R9 equal input count", got_cnt, 2);

    // R3: 512 -> 517 trace 512,513,514,516,520,518,517
    convert(1'b0, 517, -1);
    chk(got_cnt == 7, "R3 count", got_cnt, 7);
    chk(tr[1] == 513 && tr[2] == 514 && tr[3] == 516 && tr[4] == 520, "R3 growth", tr[4], 520);
    chk(tr[5] == 518 && tr[6] == 517, "R3 bisect", tr[5], 518);

    // R8: window mode 517 -> 517 trace 525,509,517,513,515,516
    convert(1'b1, 517, -1);
    chk(got_cnt == 6, "R8 count", got_cnt, 6);
    chk(tr[0] == 525 && tr[1] == 509, "R8 window edges", tr[0], 525);
    chk(tr[2] == 517 && tr[3] == 513 && tr[4] == 515 && tr[5] == 516, "R8 bisect", tr[3], 513);

    // R6: result held while idle, inputs moving
    vin = 3;
    repeat (6) @(negedge clk);
    chk(int'(code) == 517 && int'(ncmp) == 6, "R6 hold", int'(code), 517);
    chk(done == 1'b0, "R6 no extra strobe", int'(done), 0);

    // R4 upper rail: 1010 -> 1023 trace ...,1018,1023,1021,1022
    convert(1'b0, 1010, -1);
    convert(1'b0, 1023, -1);
    chk(got_cnt == 8, "R4 upper rail count", got_cnt, 8);
    chk(tr[4] == 1018 && tr[5] == 1023, "R4 upper clamp", tr[5], 1023);
    chk(tr[6] == 1021 && tr[7] == 1022, "R4 bisect after rail", tr[6], 1021);

    // R4 lower rail: 5 -> 0 trace 5,4,3,1,0
    convert(1'b0, 5, -1);
    convert(1'b0, 0, -1);
    chk(got_cnt == 5, "R4 lower rail count", got_cnt, 5);
    chk(tr[3] == 1 && tr[4] == 0, "R4 lower clamp", tr[4], 0);

    // R7: start in window mode during a tracking run 0 -> 300 (19 decisions)
    convert(1'b0, 300, 3);
    chk(got_cnt == 19, "R7 ignored start count", got_cnt, 19);
    chk(tr[3] == 4 && tr[4] == 8, "R7 trials unchanged", tr[4], 8);

    // vector table: slow ramp mixed with jumps
    prev = 300;
    for (int i = 0; i < N_VEC; i++) begin
      convert(VEC_SUB[i], VEC_VIN[i], -1);
      if (!VEC_SUB[i] && (VEC_VIN[i] - prev <= 2) && (prev - VEC_VIN[i] <= 2))
        chk(got_cnt < RES_W, "R9 close input count", got_cnt, RES_W - 1);
      prev = VEC_VIN[i];
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule